// File: doc/BRIEF.md
# Interrupt Entry Controller

This block sits beside the fetch and execute stages of a small 32-bit core and decides when an interrupt-class event is entered. It knows three classes of event. The first is a reset request. The second is a non-maskable interrupt (NMI). The third is one of `NUM_SRC` maskable sources, six by default.

Requests are recorded in pending flags as they arrive. They are judged only when the core raises its instruction-boundary strobe. When an event is taken, the block does four things in one step:
- It rewrites the processor status word (PSW), which it owns.
- It fills the save pair that belongs to the event class: the interrupted PC and the PSW as it was.
- It writes the cause register.
- It sends the fetch stage a one-cycle redirect together with the new PC.

A PSW write port lets the core replace the status word. The return-from-interrupt path uses it to clear the in-NMI and interrupt-disable bits.

The control is a two-state machine:
- `ST_RUN`: the block is waiting for a boundary.
- `ST_REDIRECT`: the cycle in which the redirect pulse is presented.

Its transitions are:
- *take* (`ST_RUN` to `ST_REDIRECT`): an event is accepted at a boundary.
- *stay* (`ST_RUN` to `ST_RUN`): no event is accepted.
- *resume* (`ST_REDIRECT` to `ST_RUN`): this happens unconditionally after one cycle.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A taken reset request sets new PC to 0, PSW to 0x20 and the cause register to 0. It also discards every pending NMI and maskable request. The save registers are left alone.
- R2: `redirect_o` is high for exactly one cycle per taken event. `new_pc_o` is valid while it is high and holds its value afterwards.
- R3: An NMI is taken only while PSW bit 7 (in-NMI) is 0. While that bit is 1, any number of further NMI pulses collapse into one pending NMI. That NMI is taken once, at the first boundary after the bit is cleared.
- R4: Taking an NMI stores the boundary-cycle `cur_pc_i` and the old PSW in the NMI save pair. It sets PSW bits 7 and 5, clears PSW bit 6 (exception-in-progress), and sends new PC 0x10.
- R5: Taking an NMI writes 0x0010 into cause bits 31:16 and leaves cause bits 15:0 unchanged.
- R6: A maskable request is taken only when PSW bit 7 and bit 5 (interrupt-disable) are both 0. If either bit is set, the request stays pending and is reconsidered at every later boundary.
- R7: Taking a maskable interrupt stores `cur_pc_i` and the old PSW in the interrupt save pair. It sets PSW bit 5, clears PSW bit 6, and leaves the other PSW bits unchanged.
- R8: Source i (bit i of `irq_req_i`) uses vector 0x80 + 0x10*i, so sources 0 to 5 give 0x80 to 0xD0. That value becomes the new PC and is written into cause bits 15:0; cause bits 31:16 are kept.
- R9: When several events are eligible at once, the order is reset request, then NMI, then the maskable source with the lowest index.
- R10: Events are taken only when `boundary_i` is high in `ST_RUN`. A boundary in `ST_REDIRECT` is ignored. A request pulse becomes eligible at the first boundary after the cycle in which it was recorded.
- R11: Each maskable source has its own sticky pending flag. The flag is cleared only when that source is taken, or when a reset request is taken.
- R12: With `psw_wr_en_i` high, `psw_o` takes `psw_wr_data_i` on the next cycle, unless an event is taken in the same cycle. In that case the event's PSW update wins and the write is dropped.
- R13: After `rst_n` is asserted, the outputs are: redirect 0, new PC 0, PSW 0x20, cause 0, and all four save registers 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| cur_pc_i | input | XLEN | PC of the instruction at the boundary |
| rst_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | NMI request pulse |
| irq_req_i | input | NUM_SRC | Maskable request pulses, one per source |
| psw_wr_en_i | input | 1 | PSW write enable |
| psw_wr_data_i | input | XLEN | PSW write value |
| redirect_o | output | 1 | One-cycle fetch redirect |
| new_pc_o | output | XLEN | Target PC of the last taken event |
| psw_o | output | XLEN | Current PSW |
| nmi_save_pc_o | output | XLEN | PC saved on NMI entry |
| nmi_save_psw_o | output | XLEN | PSW saved on NMI entry |
| irq_save_pc_o | output | XLEN | PC saved on maskable entry |
| irq_save_psw_o | output | XLEN | PSW saved on maskable entry |
| cause_o | output | XLEN | Cause register: NMI code in the upper half, maskable code in the lower half |

## Verification
The assertions rely on the default vector layout. In it, the NMI vector and 0 both differ from every maskable vector, so the class of each redirect can be told from `new_pc_o` alone.

They also rely on `psw_wr_en_i` and the request inputs being driven only between clock edges. The stimulus sets all inputs on the falling edge.

The random phase keeps PSW writes to the low byte. This makes the in-NMI and disable bits toggle often, while the upper bits stay clear.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int PSW_ID_BIT = 5;
    localparam int PSW_EP_BIT = 6;
    localparam int PSW_NP_BIT = 7;
    localparam logic [31:0] PSW_BOOT = 32'h0000_0020;

    typedef enum logic {
        ST_RUN,
        ST_REDIRECT
    } entry_state_e;

    typedef enum logic [1:0] {
        TAKE_NONE,
        TAKE_RESET,
        TAKE_NMI,
        TAKE_MASK
    } take_e;
endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req_i,
    input  logic               nmi_req_i,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               take_rst_i,
    input  logic               take_nmi_i,
    input  logic [NUM_SRC-1:0] take_irq_i,
    output logic               rst_pend_o,
    output logic               nmi_pend_o,
    output logic [NUM_SRC-1:0] irq_pend_o
);
    // Reset request slot: a new request in the taking cycle re-arms it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pend_o <= 1'b0;
        end else begin
            rst_pend_o <= rst_req_i | (rst_pend_o & ~take_rst_i);
        end
    end

    // Single NMI slot: repeated pulses collapse, a pulse during acceptance survives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pend_o <= 1'b0;
        end else if (take_rst_i) begin
            nmi_pend_o <= 1'b0;
        end else begin
            nmi_pend_o <= nmi_req_i | (nmi_pend_o & ~take_nmi_i);
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (take_rst_i) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= irq_req_i[g] | (flag_q & ~take_irq_i[g]);
            end
        end
        assign irq_pend_o[g] = flag_q;
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int NUM_SRC = 6,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               grant_valid_o,
    output logic [IDX_W-1:0]   grant_idx_o
);
    // Scan from the top so the lowest pending index is the last to land.
    always_comb begin
        grant_valid_o = 1'b0;
        grant_idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                grant_valid_o = 1'b1;
                grant_idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NUM_SRC  = 6,
    parameter int NMI_VEC  = 32'h10,
    parameter int VEC_BASE = 32'h80,
    parameter int VEC_STEP = 32'h10,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic [XLEN-1:0]  cur_pc_i,
    input  logic             rst_pend_i,
    input  logic             nmi_pend_i,
    input  logic             grant_valid_i,
    input  logic [IDX_W-1:0] grant_idx_i,
    input  logic             psw_wr_en_i,
    input  logic [XLEN-1:0]  psw_wr_data_i,
    output take_e            take_o,
    output logic             redirect_o,
    output logic [XLEN-1:0]  new_pc_o,
    output logic [XLEN-1:0]  psw_o,
    output logic [XLEN-1:0]  nmi_save_pc_o,
    output logic [XLEN-1:0]  nmi_save_psw_o,
    output logic [XLEN-1:0]  irq_save_pc_o,
    output logic [XLEN-1:0]  irq_save_psw_o,
    output logic [XLEN-1:0]  cause_o
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] NMI_PC   = XLEN'(NMI_VEC);
    localparam logic [XLEN-1:0] PSW_INIT = XLEN'(PSW_BOOT);

    entry_state_e state_q, state_d;
    logic         nmi_masked, irq_masked;
    logic [XLEN-1:0] mask_vec;

    assign nmi_masked = psw_o[PSW_NP_BIT];
    assign irq_masked = psw_o[PSW_NP_BIT] | psw_o[PSW_ID_BIT];
    assign mask_vec   = XLEN'(VEC_BASE) + XLEN'(grant_idx_i) * XLEN'(VEC_STEP);

    always_comb begin
        take_o  = TAKE_NONE;
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (boundary_i) begin
                    if (rst_pend_i) begin
                        take_o = TAKE_RESET;
                    end else if (nmi_pend_i && !nmi_masked) begin
                        take_o = TAKE_NMI;
                    end else if (grant_valid_i && !irq_masked) begin
                        take_o = TAKE_MASK;
                    end
                end
                state_d = (take_o != TAKE_NONE) ? ST_REDIRECT : ST_RUN;
            end
            ST_REDIRECT: begin
                state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_o     <= 1'b0;
            new_pc_o       <= '0;
            psw_o          <= PSW_INIT;
            nmi_save_pc_o  <= '0;
            nmi_save_psw_o <= '0;
            irq_save_pc_o  <= '0;
            irq_save_psw_o <= '0;
            cause_o        <= '0;
        end else begin
            redirect_o <= (take_o != TAKE_NONE);
            unique case (take_o)
                TAKE_RESET: begin
                    new_pc_o <= '0;
                    psw_o    <= PSW_INIT;
                    cause_o  <= '0;
                end
                TAKE_NMI: begin
                    nmi_save_pc_o            <= cur_pc_i;
                    nmi_save_psw_o           <= psw_o;
                    psw_o[PSW_NP_BIT]        <= 1'b1;
                    psw_o[PSW_ID_BIT]        <= 1'b1;
                    psw_o[PSW_EP_BIT]        <= 1'b0;
                    cause_o[XLEN-1:HALF]     <= NMI_PC[HALF-1:0];
                    new_pc_o                 <= NMI_PC;
                end
                TAKE_MASK: begin
                    irq_save_pc_o            <= cur_pc_i;
                    irq_save_psw_o           <= psw_o;
                    psw_o[PSW_ID_BIT]        <= 1'b1;
                    psw_o[PSW_EP_BIT]        <= 1'b0;
                    cause_o[HALF-1:0]        <= mask_vec[HALF-1:0];
                    new_pc_o                 <= mask_vec;
                end
                TAKE_NONE: begin
                    if (psw_wr_en_i) begin
                        psw_o <= psw_wr_data_i;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NUM_SRC  = 6,
    parameter int NMI_VEC  = 32'h10,
    parameter int VEC_BASE = 32'h80,
    parameter int VEC_STEP = 32'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic [XLEN-1:0]    cur_pc_i,
    input  logic               rst_req_i,
    input  logic               nmi_req_i,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               psw_wr_en_i,
    input  logic [XLEN-1:0]    psw_wr_data_i,
    output logic               redirect_o,
    output logic [XLEN-1:0]    new_pc_o,
    output logic [XLEN-1:0]    psw_o,
    output logic [XLEN-1:0]    nmi_save_pc_o,
    output logic [XLEN-1:0]    nmi_save_psw_o,
    output logic [XLEN-1:0]    irq_save_pc_o,
    output logic [XLEN-1:0]    irq_save_psw_o,
    output logic [XLEN-1:0]    cause_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic               rst_pend, nmi_pend;
    logic [NUM_SRC-1:0] irq_pend, take_irq;
    logic               grant_valid;
    logic [IDX_W-1:0]   grant_idx;
    take_e              take;

    assign take_irq = (take == TAKE_MASK) ? (NUM_SRC'(1) << grant_idx) : '0;

    irq_pend_track #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req_i  (rst_req_i),
        .nmi_req_i  (nmi_req_i),
        .irq_req_i  (irq_req_i),
        .take_rst_i (take == TAKE_RESET),
        .take_nmi_i (take == TAKE_NMI),
        .take_irq_i (take_irq),
        .rst_pend_o (rst_pend),
        .nmi_pend_o (nmi_pend),
        .irq_pend_o (irq_pend)
    );

    irq_prio_sel #(.NUM_SRC(NUM_SRC)) u_prio (
        .pend_i        (irq_pend),
        .grant_valid_o (grant_valid),
        .grant_idx_o   (grant_idx)
    );

    irq_entry_fsm #(
        .XLEN     (XLEN),
        .NUM_SRC  (NUM_SRC),
        .NMI_VEC  (NMI_VEC),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .boundary_i     (boundary_i),
        .cur_pc_i       (cur_pc_i),
        .rst_pend_i     (rst_pend),
        .nmi_pend_i     (nmi_pend),
        .grant_valid_i  (grant_valid),
        .grant_idx_i    (grant_idx),
        .psw_wr_en_i    (psw_wr_en_i),
        .psw_wr_data_i  (psw_wr_data_i),
        .take_o         (take),
        .redirect_o     (redirect_o),
        .new_pc_o       (new_pc_o),
        .psw_o          (psw_o),
        .nmi_save_pc_o  (nmi_save_pc_o),
        .nmi_save_psw_o (nmi_save_psw_o),
        .irq_save_pc_o  (irq_save_pc_o),
        .irq_save_psw_o (irq_save_psw_o),
        .cause_o        (cause_o)
    );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NMI_VEC = 32'h10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            boundary_i,
    input logic            psw_wr_en_i,
    input logic [XLEN-1:0] psw_wr_data_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] new_pc_o,
    input logic [XLEN-1:0] psw_o,
    input logic [XLEN-1:0] cause_o,
    input logic [XLEN-1:0] nmi_save_psw_o,
    input logic [XLEN-1:0] irq_save_psw_o
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] NMI_PC = XLEN'(NMI_VEC);

    logic is_rst, is_nmi, is_mask;
    assign is_rst  = redirect_o && (new_pc_o == '0);
    assign is_nmi  = redirect_o && (new_pc_o == NMI_PC);
    assign is_mask = redirect_o && !is_rst && !is_nmi;

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    a_r10_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redirect_o) |-> $past(boundary_i));

    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        is_rst |-> (psw_o == XLEN'(PSW_BOOT)) && (cause_o == '0));

    a_r3_nmi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && $past(psw_o[PSW_NP_BIT])) |-> is_rst);

    a_r4_nmi_entry: assert property (@(posedge clk) disable iff (!rst_n)
        is_nmi |-> psw_o[PSW_NP_BIT] && psw_o[PSW_ID_BIT] && !psw_o[PSW_EP_BIT]
                   && (nmi_save_psw_o == $past(psw_o)));

    a_r5_nmi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        is_nmi |-> (cause_o[XLEN-1:HALF] == NMI_PC[HALF-1:0])
                   && (cause_o[HALF-1:0] == $past(cause_o[HALF-1:0])));

    a_r6_mask_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && $past(psw_o[PSW_ID_BIT])) |-> !is_mask);

    a_r7_mask_entry: assert property (@(posedge clk) disable iff (!rst_n)
        is_mask |-> psw_o[PSW_ID_BIT] && !psw_o[PSW_EP_BIT]
                    && (irq_save_psw_o == $past(psw_o)));

    a_r8_cause_matches_vector: assert property (@(posedge clk) disable iff (!rst_n)
        is_mask |-> (cause_o[HALF-1:0] == new_pc_o[HALF-1:0])
                    && (cause_o[XLEN-1:HALF] == $past(cause_o[XLEN-1:HALF])));

    a_r12_psw_write: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_wr_en_i && !boundary_i) |=> (psw_o == $past(psw_wr_data_i)));
endmodule

bind irq_entry_ctrl irq_entry_chk #(
    .XLEN    (XLEN),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .boundary_i     (boundary_i),
    .psw_wr_en_i    (psw_wr_en_i),
    .psw_wr_data_i  (psw_wr_data_i),
    .redirect_o     (redirect_o),
    .new_pc_o       (new_pc_o),
    .psw_o          (psw_o),
    .cause_o        (cause_o),
    .nmi_save_psw_o (nmi_save_psw_o),
    .irq_save_psw_o (irq_save_psw_o)
);

// File: tb/irq_entry_ctrl_bench.sv
`timescale 1ns/1ps
module irq_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic [31:0] cur_pc_i = '0;
    logic        rst_req_i = 1'b0;
    logic        nmi_req_i = 1'b0;
    logic [5:0]  irq_req_i = '0;
    logic        psw_wr_en_i = 1'b0;
    logic [31:0] psw_wr_data_i = '0;
    logic        redirect_o;
    logic [31:0] new_pc_o, psw_o, nmi_save_pc_o, nmi_save_psw_o;
    logic [31:0] irq_save_pc_o, irq_save_psw_o, cause_o;

    always #2.5 clk = ~clk;

    irq_entry_ctrl u_irq_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .cur_pc_i(cur_pc_i),
        .rst_req_i(rst_req_i), .nmi_req_i(nmi_req_i), .irq_req_i(irq_req_i),
        .psw_wr_en_i(psw_wr_en_i), .psw_wr_data_i(psw_wr_data_i),
        .redirect_o(redirect_o), .new_pc_o(new_pc_o), .psw_o(psw_o),
        .nmi_save_pc_o(nmi_save_pc_o), .nmi_save_psw_o(nmi_save_psw_o),
        .irq_save_pc_o(irq_save_pc_o), .irq_save_psw_o(irq_save_psw_o),
        .cause_o(cause_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements
    logic        m_redir, m_inredir, m_rst_p, m_nmi_p;
    logic [5:0]  m_irq_p;
    logic [31:0] m_newpc, m_psw, m_cause, m_fpc, m_fpsw, m_epc, m_epsw;

    function automatic logic [31:0] vec_of(input int src);
        return 32'h80 + 32'(src) * 32'h10;
    endfunction

    task automatic model_init();
        m_redir = 0; m_inredir = 0; m_rst_p = 0; m_nmi_p = 0; m_irq_p = '0;
        m_newpc = 0; m_psw = 32'h20; m_cause = 0;
        m_fpc = 0; m_fpsw = 0; m_epc = 0; m_epsw = 0;
    endtask

    task automatic model_step(input logic bnd, rr, nr, input logic [5:0] ir,
                              input logic we, input logic [31:0] wd, input logic [31:0] pc);
        int take = 0;
        int idx = 0;
        if (!m_inredir && bnd) begin
            if (m_rst_p) take = 1;
            else if (m_nmi_p && !m_psw[7]) take = 2;
            else if (m_irq_p != 0 && !m_psw[7] && !m_psw[5]) begin
                take = 3;
                for (int i = 5; i >= 0; i--) if (m_irq_p[i]) idx = i;
            end
        end
        if (take == 1) begin
            m_nmi_p = 0; m_irq_p = '0;
        end else begin
            m_nmi_p = nr | (m_nmi_p & (take != 2));
            m_irq_p = ir | (m_irq_p & ~((take == 3) ? 6'(1 << idx) : 6'd0));
        end
        m_rst_p = rr | (m_rst_p & (take != 1));
        case (take)
            1: begin m_newpc = 0; m_psw = 32'h20; m_cause = 0; end
            2: begin
                m_fpc = pc; m_fpsw = m_psw;
                m_psw[7] = 1; m_psw[5] = 1; m_psw[6] = 0;
                m_cause[31:16] = 16'h0010; m_newpc = 32'h10;
            end
            3: begin
                m_epc = pc; m_epsw = m_psw;
                m_psw[5] = 1; m_psw[6] = 0;
                m_newpc = vec_of(idx); m_cause[15:0] = m_newpc[15:0];
            end
            default: if (we) m_psw = wd;
        endcase
        m_redir = (take != 0);
        m_inredir = (take != 0);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] got, exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "redirect", 32'(redirect_o), 32'(m_redir));
        chk(tag, "new_pc", new_pc_o, m_newpc);
        chk(tag, "psw", psw_o, m_psw);
        chk(tag, "cause", cause_o, m_cause);
        chk(tag, "nmi_save_pc", nmi_save_pc_o, m_fpc);
        chk(tag, "nmi_save_psw", nmi_save_psw_o, m_fpsw);
        chk(tag, "irq_save_pc", irq_save_pc_o, m_epc);
        chk(tag, "irq_save_psw", irq_save_psw_o, m_epsw);
    endtask

    task automatic tick(input string tag, input logic bnd, rr, nr, input logic [5:0] ir,
                        input logic we, input logic [31:0] wd);
        logic [31:0] pc;
        pc = $urandom & 32'hFFFF_FFFC;
        boundary_i = bnd; rst_req_i = rr; nmi_req_i = nr; irq_req_i = ir;
        psw_wr_en_i = we; psw_wr_data_i = wd; cur_pc_i = pc;
        @(posedge clk);
        model_step(bnd, rr, nr, ir, we, wd, pc);
        @(negedge clk);
        boundary_i = 0; rst_req_i = 0; nmi_req_i = 0; irq_req_i = '0; psw_wr_en_i = 0;
        compare_all(tag);
    endtask

    task automatic idle(input string tag, input int n, input logic bnd);
        for (int k = 0; k < n; k++) tick(tag, bnd, 0, 0, '0, 0, '0);
    endtask

    task automatic pswwr(input string tag, input logic [31:0] v);
        tick(tag, 0, 0, 0, '0, 1, v);
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R13");
        idle("R13", 2, 1);

        pswwr("R12", 32'h0);
        // R10: request without boundary leaves outputs alone
        tick("R10", 0, 0, 0, 6'b000001, 0, '0);
        idle("R10", 3, 0);
        tick("R8", 1, 0, 0, '0, 0, '0);
        idle("R2", 2, 0);
        for (int s = 1; s < 6; s++) begin
            pswwr("R12", 32'h0);
            tick("R8", 0, 0, 0, 6'(1 << s), 0, '0);
            tick("R8", 1, 0, 0, '0, 0, '0);
            tick("R10", 1, 0, 0, '0, 0, '0); // boundary during redirect ignored
        end

        // R9 lowest index first, R11 loser stays pending
        pswwr("R9", 32'h0);
        tick("R9", 0, 0, 0, 6'b010100, 0, '0);
        tick("R9", 1, 0, 0, '0, 0, '0);
        idle("R9", 1, 0);
        pswwr("R11", 32'h0);
        tick("R11", 1, 0, 0, '0, 0, '0);

        // R6 masked while ID set, taken once cleared
        pswwr("R6", 32'h20);
        tick("R6", 0, 0, 0, 6'b000010, 0, '0);
        idle("R6", 3, 1);
        pswwr("R6", 32'h80);
        idle("R6", 2, 1);
        pswwr("R6", 32'h0);
        tick("R6", 1, 0, 0, '0, 0, '0);

        // R4 / R5 NMI entry, R3 collapse of repeated NMIs
        pswwr("R4", 32'h0000_004F);
        tick("R4", 0, 0, 1, '0, 0, '0);
        tick("R5", 1, 0, 0, '0, 0, '0);
        tick("R3", 1, 0, 1, '0, 0, '0);
        tick("R3", 1, 0, 1, '0, 0, '0);
        idle("R3", 2, 1);
        pswwr("R3", 32'h0);
        tick("R3", 1, 0, 0, '0, 0, '0);
        idle("R3", 1, 0);
        pswwr("R3", 32'h0);
        idle("R3", 2, 1);

        // R7 maskable entry keeps unrelated PSW bits
        pswwr("R7", 32'h0000_004F);
        tick("R7", 0, 0, 0, 6'b100000, 0, '0);
        tick("R7", 1, 0, 0, '0, 0, '0);

        // R1 / R9 reset wins and flushes the others
        pswwr("R1", 32'h0);
        tick("R1", 0, 1, 1, 6'b111111, 0, '0);
        tick("R1", 1, 0, 0, '0, 0, '0);
        pswwr("R1", 32'h0);
        idle("R1", 2, 1);

        // R12 an entry beats a same-cycle PSW write
        tick("R12", 0, 0, 0, 6'b000001, 0, '0);
        tick("R12", 1, 0, 0, '0, 1, 32'h0000_00FF);

        for (int n = 0; n < 4000; n++) begin
            tick("R11", ($urandom % 3) == 0, ($urandom % 97) == 0, ($urandom % 23) == 0,
                 {($urandom % 11) == 0, ($urandom % 11) == 0, ($urandom % 11) == 0,
                  ($urandom % 11) == 0, ($urandom % 11) == 0, ($urandom % 11) == 0},
                 ($urandom % 7) == 0, $urandom & 32'h0000_00FF);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule